// File: doc/BRIEF.md
# Dual priority request encoder

The block looks at eight request lines and finds two winners at once: the highest-priority request that is set, and the next one down. Request 7 ranks highest and request 0 lowest. Each winner is reported as a 3-bit index with its own valid flag. The valid flag for the second winner is set only when at least two requests are present.

The decision is made by combinational logic. The second winner is found by clearing the first winner's bit and encoding the requests that remain. One output register stage follows the logic for timing, so a request vector seen at a rising clock edge shows up on the outputs right after that edge. An active-low asynchronous reset clears the outputs.

Top module: `dual_req_encoder`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0, whatever `req` holds.
- R2: `top_vld` is 1 exactly when the `req` value sampled at the previous rising edge has at least one bit set.
- R3: When `top_vld` is 1, `top_idx` is the position of the highest set bit of the sampled `req`. Bit 7 has the highest priority.
- R4: `next_vld` is 1 exactly when the sampled `req` has two or more bits set. It is never 1 while `top_vld` is 0.
- R5: When `next_vld` is 1, `next_idx` is the position of the highest set bit strictly below `top_idx`.
- R6: An index whose valid flag is 0 reads as 0.
- R7: The outputs follow `req` with one clock of latency. A value sampled at edge k is visible after edge k and holds until edge k+1.
- R8: A sampled `req` of 8'b01001001 gives `top_idx`=6 and `next_idx`=3, with both flags set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Request vector, bit 7 highest priority |
| top_idx | output | 3 | Index of the highest set request |
| top_vld | output | 1 | A first winner exists |
| next_idx | output | 3 | Index of the second-highest set request |
| next_vld | output | 1 | A second winner exists |

## Verification
Both winners are settled in the same cycle, so any fault in how the first winner is masked shows up on the second result in that same cycle. The bench applies all 256 request patterns on consecutive clocks. This covers adjacent pairs such as bits 7 and 6, and pairs at the bottom such as bits 1 and 0. For every pattern the bench compares both indices and both flags together against a reference that ranks the set bits by counting down from the top. A reset asserted in the middle of the run, with requests still driven, checks that all four outputs clear together.

// File: rtl/dual_req_encoder.sv
module dual_req_encoder #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [IW-1:0] top_idx,
  output logic          top_vld,
  output logic [IW-1:0] next_idx,
  output logic          next_vld
);

  logic [IW-1:0] a_idx, b_idx;
  logic          a_vld, b_vld;
  logic [N-1:0]  rest;

  always_comb begin
    a_idx = '0;
    a_vld = 1'b0;
    for (int i = 0; i < N; i++)
      if (req[i]) begin
        a_idx = IW'(i);
        a_vld = 1'b1;
      end
  end

  assign rest = a_vld ? (req & ~(N'(1) << a_idx)) : '0;

  always_comb begin
    b_idx = '0;
    b_vld = 1'b0;
    for (int i = 0; i < N; i++)
      if (rest[i]) begin
        b_idx = IW'(i);
        b_vld = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      top_idx  <= '0;
      top_vld  <= 1'b0;
      next_idx <= '0;
      next_vld <= 1'b0;
    end else begin
      top_idx  <= a_idx;
      top_vld  <= a_vld;
      next_idx <= b_idx;
      next_vld <= b_vld;
    end

endmodule

module dual_req_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] req,
  input logic [2:0] top_idx,
  input logic       top_vld,
  input logic [2:0] next_idx,
  input logic       next_vld
);

  logic [7:0] req_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q <= '0;
      armed <= 1'b0;
    end else begin
      req_q <= req;
      armed <= 1'b1;
    end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (top_idx == 3'd0 && !top_vld && next_idx == 3'd0 && !next_vld));

  p_top_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (top_vld == (req_q != 8'd0)));

  p_top_highest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && top_vld) |-> (req_q[top_idx] && ((req_q >> top_idx) == 8'd1)));

  p_next_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (next_vld == ($countones(req_q) >= 2)));

  p_next_needs_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    next_vld |-> top_vld);

  p_next_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && next_vld) |-> (next_idx < top_idx && req_q[next_idx]
      && ((req_q >> next_idx) & 8'hFE) == (8'd1 << (top_idx - next_idx))));

  p_idx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_vld |-> top_idx == 3'd0) and (!next_vld |-> next_idx == 3'd0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $stable(req_q)) |-> ($stable(top_idx) && $stable(next_idx)));

endmodule

bind dual_req_encoder dual_req_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req),
  .top_idx(top_idx), .top_vld(top_vld),
  .next_idx(next_idx), .next_vld(next_vld)
);

// File: tb/sim_dual_req_encoder.sv
module sim_dual_req_encoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = 8'hFF;
  logic [2:0] top_idx, next_idx;
  logic       top_vld, next_vld;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_req;

  always #5 clk = ~clk;

  dual_req_encoder u0 (
    .clk(clk), .rst_n(rst_n), .req(req),
    .top_idx(top_idx), .top_vld(top_vld),
    .next_idx(next_idx), .next_vld(next_vld)
  );

  function automatic logic [7:0] model(input logic [7:0] v);
    int found = 0;
    logic [2:0] a = 0, b = 0;
    logic av = 0, bv = 0;
    for (int k = 7; k >= 0; k--)
      if (v[k]) begin
        if (found == 0) begin a = 3'(k); av = 1; end
        else if (found == 1) begin b = 3'(k); bv = 1; end
        found++;
      end
    return {av, a, bv, b};
  endfunction

  task automatic compare(input logic [7:0] exp, input string tag);
    logic [7:0] got = {top_vld, top_idx, next_vld, next_idx};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: req=%b got vld/idx=%b/%0d %b/%0d expected %b/%0d %b/%0d",
               tag, last_req, got[7], got[6:4], got[3], got[2:0],
               exp[7], exp[6:4], exp[3], exp[2:0]);
    end
  endtask

  task automatic step(input logic [7:0] v, input string tag);
    @(negedge clk);
    compare(model(last_req), tag);
    req = v;
    last_req = v;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        compare(8'h00, "R1 reset with requests driven");
        rst_n = 1'b1;
        last_req = 8'hFF;
        step(8'b01001001, "R2/R3/R5 all requests set");
        step(8'h00, "R8 example 01001001");
        step(8'b11000000, "R2/R6 no requests");
        step(8'b00000011, "R5 adjacent top pair");
        step(8'b00000001, "R5 adjacent bottom pair");
        step(8'b10000000, "R4/R6 single low request");
        // R7: hold a value for two clocks, outputs must stay put
        step(8'b00100100, "R4/R6 single top request");
        step(8'b00100100, "R7 first cycle of hold");
        for (int v = 0; v < 256; v++)
          step(8'(v), "R3/R4/R5 sweep");
        step(8'b10010000, "R3/R4/R5 sweep end");
        @(negedge clk);
        rst_n = 1'b0;
        #1 compare(8'h00, "R1 mid-run reset");
        @(negedge clk);
        compare(8'h00, "R1 reset held");
        rst_n = 1'b1;
        step(8'b00011000, "R2/R3/R5 after reset release");
        step(8'h00, "R5 pair 4,3");
        @(negedge clk);
        compare(model(8'h00), "R6 final idle");
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule